// File: doc/BRIEF.md
# Phase Lock Monitor with Digital Filtering

This block decides whether a phase-locked loop has settled. It watches two clocks that the loop already divides down: the reference and the divided oscillator. It runs from a fast sampling clock that is asynchronous to both. Each input passes through a synchronizer, and the block finds the rising edge on each one. The phase error of one cycle pair is the number of sampling-clock periods between the two rising edges. It does not matter which edge comes first. If the second edge never arrives, the count stops at its maximum value and that cycle counts as a measurement.

The block does not judge every measurement. It judges only every `EVAL_PERIOD`-th measurement after reset, and it ignores the rest. A judged measurement is good when its error is strictly below the `err_limit` input, which is a threshold in sampling-clock periods. The lock output rises only after `GOOD_RUN` good judgements in a row. It falls on the first bad judgement. The enable input gates the output, so the output reads low while the enable is low.

The block is meant to drive a lock pin or a status line that other logic polls. It is set up by choosing the sampling-clock rate and the threshold input, so that the threshold matches the phase window the system needs.

Top module: `phase_lock_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `lock_out` is low after that edge, and the count of consecutive good judgements restarts from zero.
- R2: The phase error is the number of `clk_smp` periods between the synchronized rising edges of `ref_clk_in` and `fb_clk_in`. This holds whether the reference edge leads or lags. Simultaneous edges give an error of 0.
- R3: Only every `EVAL_PERIOD`-th measurement counted from reset is judged. The judged measurements are numbers `EVAL_PERIOD`, 2·`EVAL_PERIOD` and so on. Measurements in other positions have no effect on `lock_out`, whatever their error.
- R4: `lock_out` goes high (1 means locked) only after `GOOD_RUN` consecutive judged measurements are good. After `GOOD_RUN`-1 good judgements it is still low.
- R5: A single bad judgement drives `lock_out` low. The next rise then needs a fresh run of `GOOD_RUN` good judgements.
- R6: If the second edge of a pair does not come within 2^`ERR_W`-1 sampling periods, the measurement closes at that saturated value. The saturated value is always judged bad. Measuring continues normally on the next edge.
- R7: While `det_en` is 0, `lock_out` is 0 in the same cycle. The judging continues while the output is disabled. When `det_en` returns to 1, the output shows the lock state that has built up in the meantime.
- R8: A judgement is good only when the error is strictly less than `err_limit`. An error equal to `err_limit` is bad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_smp | input | 1 | Fast sampling clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_in | input | 1 | Divided reference clock, asynchronous to clk_smp |
| fb_clk_in | input | 1 | Divided oscillator clock, asynchronous to clk_smp |
| det_en | input | 1 | 1 lets the lock state through; 0 holds lock_out low |
| err_limit | input | ERR_W | Phase-error threshold in sampling-clock periods |
| lock_out | output | 1 | Filtered lock indication, 1 when locked |

## Verification
The hardest case to reach from the ports is one where a judged measurement disagrees with the measurements around it. In that case only the position count inside the block separates an effect on the output from no effect. The bench keeps that count in step with the design. Every stimulus period has both leading edges, or a lone reference edge that times out, inside a fixed window, so each period yields exactly one measurement. The bench can then make the judged period the only good one, or the only bad one, in its group. A sweep of every threshold against every lead and lag offset in a small configuration covers the boundary where the error equals the limit.

// File: rtl/lockdet_pkg.sv
// Shared types for the phase lock monitor.
// Assumes: two monitored inputs, index 0 is the reference, index 1 the feedback.
package lockdet_pkg;

    localparam int NUM_MON = 2;
    localparam int IDX_REF = 0;
    localparam int IDX_FB  = 1;

    // State of the edge-pair phase meter.
    typedef enum logic [1:0] {
        MTR_IDLE     = 2'd0,
        MTR_WAIT_REF = 2'd1,
        MTR_WAIT_FB  = 2'd2
    } mtr_state_t;

endpackage

// File: rtl/lockdet_edge_sync.sv
// Synchronizes one asynchronous level into clk_smp and flags its rising edge.
// Assumes: STAGES >= 2; the pulse lasts one clk_smp cycle per input rise.
module lockdet_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_smp,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);

    logic [STAGES-1:0] sync_sh;
    logic              last_q;

    // Shift the input through the synchronizer chain and keep the last level.
    always_ff @(posedge clk_smp) begin
        if (!rst_n) begin
            sync_sh <= '0;
            last_q  <= 1'b0;
        end else begin
            sync_sh <= {sync_sh[STAGES-2:0], async_in};
            last_q  <= sync_sh[STAGES-1];
        end
    end

    // Rising edge of the synchronized level.
    always_comb begin
        rise_pulse = sync_sh[STAGES-1] & ~last_q;
    end

endmodule

// File: rtl/lockdet_phase_meter.sv
// Measures clk_smp periods between the reference and feedback rising edges.
// The first edge of either kind opens the window, the other edge closes it.
// If the closing edge is late, the measurement ends at the all-ones value.
// Assumes: a repeated opening edge inside a window is ignored.
module lockdet_phase_meter
    import lockdet_pkg::*;
#(
    parameter int ERR_W = 6
) (
    input  logic             clk_smp,
    input  logic             rst_n,
    input  logic             ref_rise,
    input  logic             fb_rise,
    output logic             meas_valid,
    output logic [ERR_W-1:0] meas_err
);

    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

    mtr_state_t       state_q;
    logic [ERR_W-1:0] span_q;
    logic             closing_edge;

    // Select the edge that closes the open window.
    always_comb begin
        closing_edge = (state_q == MTR_WAIT_FB) ? fb_rise : ref_rise;
    end

    // Window state, span counter and the one-cycle result strobe.
    always_ff @(posedge clk_smp) begin
        if (!rst_n) begin
            state_q    <= MTR_IDLE;
            span_q     <= '0;
            meas_valid <= 1'b0;
            meas_err   <= '0;
        end else begin
            meas_valid <= 1'b0;
            case (state_q)
                MTR_IDLE: begin
                    if (ref_rise && fb_rise) begin
                        meas_valid <= 1'b1;
                        meas_err   <= '0;
                    end else if (ref_rise) begin
                        state_q <= MTR_WAIT_FB;
                        span_q  <= ERR_W'(1);
                    end else if (fb_rise) begin
                        state_q <= MTR_WAIT_REF;
                        span_q  <= ERR_W'(1);
                    end
                end
                MTR_WAIT_REF, MTR_WAIT_FB: begin
                    if (closing_edge) begin
                        meas_valid <= 1'b1;
                        meas_err   <= span_q;
                        state_q    <= MTR_IDLE;
                    end else if (span_q == ERR_MAX) begin
                        meas_valid <= 1'b1;
                        meas_err   <= ERR_MAX;
                        state_q    <= MTR_IDLE;
                    end else begin
                        span_q <= span_q + ERR_W'(1);
                    end
                end
                default: state_q <= MTR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lockdet_eval_gate.sv
// Passes only every EVAL_PERIOD-th measurement on for judging and
// compares it with the threshold (good when strictly below it).
// Assumes: EVAL_PERIOD >= 2.
module lockdet_eval_gate #(
    parameter int ERR_W       = 6,
    parameter int EVAL_PERIOD = 64
) (
    input  logic             clk_smp,
    input  logic             rst_n,
    input  logic             meas_valid,
    input  logic [ERR_W-1:0] meas_err,
    input  logic [ERR_W-1:0] err_limit,
    output logic             eval_stb,
    output logic             eval_good
);

    localparam int POS_W = $clog2(EVAL_PERIOD);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(EVAL_PERIOD - 1);

    logic [POS_W-1:0] pos_q;

    // Count measurements and judge the one that completes each group.
    always_ff @(posedge clk_smp) begin
        if (!rst_n) begin
            pos_q     <= '0;
            eval_stb  <= 1'b0;
            eval_good <= 1'b0;
        end else begin
            eval_stb <= 1'b0;
            if (meas_valid) begin
                if (pos_q == POS_LAST) begin
                    pos_q     <= '0;
                    eval_stb  <= 1'b1;
                    eval_good <= (meas_err < err_limit);
                end else begin
                    pos_q <= pos_q + POS_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/lockdet_run_filter.sv
// Asymmetric filter: GOOD_RUN consecutive good judgements set the lock,
// a single bad one clears it along with the run count.
// Assumes: GOOD_RUN >= 1.
module lockdet_run_filter #(
    parameter int GOOD_RUN = 4
) (
    input  logic clk_smp,
    input  logic rst_n,
    input  logic eval_stb,
    input  logic eval_good,
    output logic lock_q
);

    localparam int RUN_W = $clog2(GOOD_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(GOOD_RUN);
    localparam logic [RUN_W-1:0] RUN_NEAR = RUN_W'(GOOD_RUN - 1);

    logic [RUN_W-1:0] run_q;

    // Update the good-run counter and the lock flag on each judgement.
    always_ff @(posedge clk_smp) begin
        if (!rst_n) begin
            run_q  <= '0;
            lock_q <= 1'b0;
        end else if (eval_stb) begin
            if (eval_good) begin
                if (run_q != RUN_FULL) begin
                    run_q <= run_q + RUN_W'(1);
                end
                if (run_q >= RUN_NEAR) begin
                    lock_q <= 1'b1;
                end
            end else begin
                run_q  <= '0;
                lock_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/phase_lock_monitor.sv
// Top of the digitally filtered lock monitor.
// Synchronizes both divided clocks, measures their edge spacing, judges one
// measurement per group and filters the result. det_en gates the output
// without disturbing the internal state.
// Assumes: clk_smp is much faster than the monitored clocks.
module phase_lock_monitor
    import lockdet_pkg::*;
#(
    parameter int ERR_W       = 6,
    parameter int EVAL_PERIOD = 64,
    parameter int GOOD_RUN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_smp,
    input  logic             rst_n,
    input  logic             ref_clk_in,
    input  logic             fb_clk_in,
    input  logic             det_en,
    input  logic [ERR_W-1:0] err_limit,
    output logic             lock_out
);

    logic [NUM_MON-1:0] raw_in;
    logic [NUM_MON-1:0] rise_vec;
    logic               meas_valid;
    logic [ERR_W-1:0]   meas_err;
    logic               eval_stb;
    logic               eval_good;
    logic               lock_q;

    // Gather the monitored clocks into one vector.
    always_comb begin
        raw_in[IDX_REF] = ref_clk_in;
        raw_in[IDX_FB]  = fb_clk_in;
    end

    for (genvar gi = 0; gi < NUM_MON; gi++) begin : g_sync
        lockdet_edge_sync #(
            .STAGES(SYNC_STAGES)
        ) u_sync (
            .clk_smp   (clk_smp),
            .rst_n     (rst_n),
            .async_in  (raw_in[gi]),
            .rise_pulse(rise_vec[gi])
        );
    end

    lockdet_phase_meter #(
        .ERR_W(ERR_W)
    ) u_meter (
        .clk_smp   (clk_smp),
        .rst_n     (rst_n),
        .ref_rise  (rise_vec[IDX_REF]),
        .fb_rise   (rise_vec[IDX_FB]),
        .meas_valid(meas_valid),
        .meas_err  (meas_err)
    );

    lockdet_eval_gate #(
        .ERR_W      (ERR_W),
        .EVAL_PERIOD(EVAL_PERIOD)
    ) u_gate (
        .clk_smp   (clk_smp),
        .rst_n     (rst_n),
        .meas_valid(meas_valid),
        .meas_err  (meas_err),
        .err_limit (err_limit),
        .eval_stb  (eval_stb),
        .eval_good (eval_good)
    );

    lockdet_run_filter #(
        .GOOD_RUN(GOOD_RUN)
    ) u_filter (
        .clk_smp  (clk_smp),
        .rst_n    (rst_n),
        .eval_stb (eval_stb),
        .eval_good(eval_good),
        .lock_q   (lock_q)
    );

    // Output gating by the enable bit.
    always_comb begin
        lock_out = lock_q & det_en;
    end

endmodule

// File: rtl/phase_lock_monitor_chk.sv
// Assertion checker for phase_lock_monitor, attached by bind.
module phase_lock_monitor_chk #(
    parameter int GOOD_RUN = 4
) (
    input logic clk_smp,
    input logic rst_n,
    input logic det_en,
    input logic meas_valid,
    input logic eval_stb,
    input logic eval_good,
    input logic lock_q,
    input logic lock_out
);

    logic [7:0] good_seen;

    // Independent tally of consecutive good judgements before the current one.
    always_ff @(posedge clk_smp) begin
        if (!rst_n) begin
            good_seen <= '0;
        end else if (eval_stb) begin
            if (!eval_good) begin
                good_seen <= '0;
            end else if (good_seen != 8'hFF) begin
                good_seen <= good_seen + 8'd1;
            end
        end
    end

    // R1
    reset_low_chk: assert property (@(posedge clk_smp)
        !rst_n |=> !lock_out);

    // R7
    enable_gate_chk: assert property (@(posedge clk_smp) disable iff (!rst_n)
        !det_en |-> !lock_out);

    // R3
    judge_on_meas_chk: assert property (@(posedge clk_smp) disable iff (!rst_n)
        eval_stb |-> $past(meas_valid));

    // R5
    bad_drop_chk: assert property (@(posedge clk_smp) disable iff (!rst_n)
        (eval_stb && !eval_good) |=> !lock_q);

    // R4
    short_run_chk: assert property (@(posedge clk_smp) disable iff (!rst_n)
        (eval_stb && eval_good && (good_seen < 8'(GOOD_RUN - 1)) && !lock_q) |=> !lock_q);

    // R4
    rise_cause_chk: assert property (@(posedge clk_smp) disable iff (!rst_n)
        $rose(lock_q) |-> $past(eval_stb && eval_good));

endmodule

bind phase_lock_monitor phase_lock_monitor_chk #(
    .GOOD_RUN(GOOD_RUN)
) u_chk (
    .clk_smp   (clk_smp),
    .rst_n     (rst_n),
    .det_en    (det_en),
    .meas_valid(meas_valid),
    .eval_stb  (eval_stb),
    .eval_good (eval_good),
    .lock_q    (lock_q),
    .lock_out  (lock_out)
);

// File: tb/phase_lock_monitor_test.sv
// Bench for phase_lock_monitor in a small configuration.
// Each stimulus period is 16 sampling clocks. The reference rises at slot 4,
// and the feedback rises at slot 4+d, so every period yields one measurement.
module phase_lock_monitor_test;

    localparam int ERR_W    = 3;
    localparam int EVAL_P   = 8;
    localparam int RUN      = 4;
    localparam int PER      = 16;
    localparam int ERR_MAX  = 7;

    logic             clk_smp = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_clk_in = 1'b0;
    logic             fb_clk_in = 1'b0;
    logic             det_en = 1'b1;
    logic [ERR_W-1:0] err_limit = '0;
    logic             lock_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk_smp = ~clk_smp;

    phase_lock_monitor #(
        .ERR_W      (ERR_W),
        .EVAL_PERIOD(EVAL_P),
        .GOOD_RUN   (RUN),
        .SYNC_STAGES(2)
    ) uut (
        .clk_smp   (clk_smp),
        .rst_n     (rst_n),
        .ref_clk_in(ref_clk_in),
        .fb_clk_in (fb_clk_in),
        .det_en    (det_en),
        .err_limit (err_limit),
        .lock_out  (lock_out)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: lock_out=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_smp);
        rst_n = 1'b0;
        ref_clk_in = 1'b0;
        fb_clk_in = 1'b0;
        repeat (3) @(negedge clk_smp);
        rst_n = 1'b1;
    endtask

    // One period; d is the feedback offset (-4..4), fb_on=0 removes its edge.
    task automatic run_period(input int d, input bit fb_on);
        for (int k = 0; k < PER; k++) begin
            @(negedge clk_smp);
            ref_clk_in = (k >= 4) && (k < 12);
            fb_clk_in  = fb_on && (k >= 4 + d) && (k < 12 + d);
        end
    endtask

    // A full group of periods, then quiet time so the judgement settles.
    task automatic run_group(input int d, input bit fb_on);
        for (int p = 0; p < EVAL_P; p++) run_period(d, fb_on);
        repeat (8) @(negedge clk_smp);
    endtask

    // A group whose judged (last) period differs from the other periods.
    task automatic run_mixed(input int d_rest, input bit fb_rest, input int d_last);
        for (int p = 0; p < EVAL_P - 1; p++) run_period(d_rest, fb_rest);
        run_period(d_last, 1'b1);
        repeat (8) @(negedge clk_smp);
    endtask

    initial begin
        repeat (150000) @(posedge clk_smp);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: output low out of reset, even with edges arriving during reset
        err_limit = 3'd7;
        do_reset();
        #1 check(lock_out, 1'b0, "R1 after reset");
        rst_n = 1'b0;
        run_period(0, 1'b1);
        rst_n = 1'b1;
        #1 check(lock_out, 1'b0, "R1 edges during reset");

        // R2/R4/R8 sweep: every threshold against every lead/lag offset
        for (int thr = 1; thr <= ERR_MAX; thr++) begin
            for (int d = -4; d <= 4; d++) begin
                int ad;
                err_limit = ERR_W'(thr);
                do_reset();
                ad = (d < 0) ? -d : d;
                for (int g = 0; g < RUN - 1; g++) run_group(d, 1'b1);
                #1 check(lock_out, 1'b0, "R4 short run stays low");
                run_group(d, 1'b1);
                #1 check(lock_out, (ad < thr) ? 1'b1 : 1'b0,
                         (ad == thr) ? "R8 equal is bad" : "R2 error vs limit");
            end
        end

        // R3: only the judged period matters
        err_limit = 3'd3;
        do_reset();
        for (int g = 0; g < RUN; g++) run_mixed(0, 1'b0, 1);
        #1 check(lock_out, 1'b1, "R3 unjudged bad ignored");
        run_mixed(0, 1'b1, 4);
        #1 check(lock_out, 1'b0, "R3 judged bad counts");

        // R5: fresh run needed after a drop
        for (int g = 0; g < RUN - 1; g++) run_group(-2, 1'b1);
        #1 check(lock_out, 1'b0, "R5 relock needs full run");
        run_group(-2, 1'b1);
        #1 check(lock_out, 1'b1, "R5 relock after full run");
        run_group(3, 1'b1);
        #1 check(lock_out, 1'b0, "R5 single bad drops");

        // R6: missing feedback saturates, is bad, and does not stall measuring
        err_limit = 3'd7;
        do_reset();
        for (int g = 0; g < RUN; g++) run_group(0, 1'b1);
        #1 check(lock_out, 1'b1, "R6 locked before loss");
        run_group(0, 1'b0);
        #1 check(lock_out, 1'b0, "R6 saturated is bad");
        for (int g = 0; g < RUN; g++) run_group(1, 1'b1);
        #1 check(lock_out, 1'b1, "R6 measuring resumes");

        // R7: enable gates at once and the state keeps evolving
        @(negedge clk_smp);
        det_en = 1'b0;
        #1 check(lock_out, 1'b0, "R7 immediate gate");
        run_group(0, 1'b1);
        #1 check(lock_out, 1'b0, "R7 held low while disabled");
        det_en = 1'b1;
        #1 check(lock_out, 1'b1, "R7 state kept while disabled");
        det_en = 1'b0;
        run_group(0, 1'b0);
        det_en = 1'b1;
        #1 check(lock_out, 1'b0, "R7 drop seen while disabled");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule